// File: doc/BRIEF.md
# Run-Length Capture Stream Decoder

This block turns the packed contents of a logic-analyser capture memory back into a plain stream of per-clock sample values. Memory words come in as 32-bit values. They are grouped in nines: eight data words, and then one word that carries the four upper bits of each of those eight. The block joins each data word with its nibble to form a 36-bit word. It then interprets that word either as a sample (a value plus a short inline repeat count) or as an extension that lengthens the pending repeat count.

Each decoded sample value is presented on a valid/ready output once per clock for as many clocks as its run length. A programmable sample limit ends emission. Once the limit is reached, remaining input is still consumed and thrown away, so the memory readout upstream always finishes. Backpressure on the output stalls run expansion, and through it stalls the intake of memory words.

Top module: `rle_capture_decoder`

## Requirements
- R1: After a synchronous active-low reset, out_valid is 0 and in_ready is 1. The decoder is in the data state with no pending run and a sample count of zero.
- R2: Input is taken in groups of nine words: eight data words, then a nibble word. Data word i (0..7) gets its bits 35:32 from nibble-word bits (31-4i):(28-4i), so word 0 uses bits 31:28.
- R3: In the data state, bits 33:0 of a 36-bit word are the sample value and the run length is bit 34 plus one (1 or 2). The value appears on out_sample for exactly that many accepted output transfers.
- R4: A data word with bit 35 set makes the next 36-bit word a length extension. That whole word, shifted left by one, is added to the pending run length, and the decoder returns to the data state.
- R5: An extension word never appears as a sample. The sample emitted is the one from the preceding data word, repeated for the combined length; an extension of 0 leaves the inline length unchanged.
- R6: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_sample stays unchanged. No sample is dropped or repeated because of the stall.
- R7: After sample_limit samples have been transferred, out_valid stays 0. Input words continue to be accepted and are discarded.
- R8: With sample_limit equal to 0, no sample is ever emitted.
- R9: From the cycle after a nibble word is accepted until all eight words of that group have been consumed, in_ready is 0. This includes any time the consumption is stalled by out_ready being 0.
- R10: A pending extension state carries across a group boundary. A follow flag in word 7 applies to word 0 of the next group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_word | input | 32 | Capture memory word |
| in_valid | input | 1 | in_word is valid |
| in_ready | output | 1 | Decoder accepts in_word this cycle |
| sample_limit | input | 32 | Number of samples to emit before stopping |
| out_sample | output | 34 | Decoded sample value |
| out_valid | output | 1 | out_sample is valid |
| out_ready | input | 1 | Downstream accepts out_sample this cycle |

## Verification
The assertions check on every cycle that a stalled output holds both its value and its valid flag. They also check that the sample counter freezes once the limit is met, that input is refused while a group is being drained, that a completed plain data word yields a valid output on the next cycle, and that a pending extension always has a nonzero inline count behind it. Only the bench scenarios can show that the expanded stream is correct. That means the right values in the right order with the right repeat counts, nibble placement per word position, extension arithmetic across a group boundary, and the exact number of samples before the limit stops output.

// File: rtl/rle_dec_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the run-length capture decoder.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package rle_dec_pkg;
    // Intake phase of the group assembler.
    typedef enum logic [1:0] {
        PH_FILL  = 2'd0,  // collecting data words
        PH_NIB   = 2'd1,  // waiting for the nibble word
        PH_DRAIN = 2'd2   // handing rebuilt words downstream
    } grp_phase_e;
endpackage

// File: rtl/rle_group_assembler.sv
`timescale 1ns/1ps
// Module: rle_group_assembler
// Collects GRP data words and one nibble word, then presents GRP rebuilt
// words of MW+NIB bits one at a time on a valid/ready port.
// Assumes GRP is a power of two and GRP*NIB == MW.
module rle_group_assembler
    import rle_dec_pkg::*;
#(
    parameter int MW  = 32,
    parameter int NIB = 4,
    parameter int GRP = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MW-1:0]     in_word,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [MW+NIB-1:0] w_word,
    output logic              w_valid,
    input  logic              w_ready
);
    localparam int IDX_W = $clog2(GRP);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(GRP - 1);

    grp_phase_e       phase_q;
    logic [IDX_W-1:0] idx_q;
    logic [MW-1:0]    nib_q;
    logic [MW-1:0]    dbuf [GRP];
    logic             in_fire;
    logic             w_fire;
    logic [MW-1:0]    nib_sh;

    assign in_ready = (phase_q != PH_DRAIN);
    assign in_fire  = in_valid && in_ready;
    assign w_valid  = (phase_q == PH_DRAIN);
    assign w_fire   = w_valid && w_ready;

    // Select the nibble belonging to the current word position (word 0 = top).
    always_comb begin
        nib_sh = nib_q >> (NIB * (GRP - 1 - int'(idx_q)));
        w_word = {nib_sh[NIB-1:0], dbuf[idx_q]};
    end

    // One storage slot per data word position.
    for (genvar g = 0; g < GRP; g++) begin : g_slot
        // Capture data word g during the fill phase.
        always_ff @(posedge clk) begin
            if (!rst_n)
                dbuf[g] <= '0;
            else if (in_fire && phase_q == PH_FILL && idx_q == IDX_W'(g))
                dbuf[g] <= in_word;
        end
    end

    // Phase sequencing, word index and nibble word capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_FILL;
            idx_q   <= '0;
            nib_q   <= '0;
        end else begin
            case (phase_q)
                PH_FILL: if (in_fire) begin
                    idx_q <= idx_q + 1'b1;
                    if (idx_q == LAST) phase_q <= PH_NIB;
                end
                PH_NIB: if (in_fire) begin
                    nib_q   <= in_word;
                    phase_q <= PH_DRAIN;
                end
                PH_DRAIN: if (w_fire) begin
                    idx_q <= idx_q + 1'b1;
                    if (idx_q == LAST) phase_q <= PH_FILL;
                end
                default: phase_q <= PH_FILL;
            endcase
        end
    end

    // R9
    nibble_closes_intake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && phase_q == PH_NIB) |=> (!in_ready && w_valid));
endmodule

// File: rtl/rle_run_fsm.sv
`timescale 1ns/1ps
// Module: rle_run_fsm
// Two-state run-length interpreter. In the data state a word supplies the
// sample value and an inline count of 1 or 2; a set follow flag makes the
// next word an extension added shifted left by one. Emits the sample once
// per accepted output transfer until the run is exhausted.
// Assumes CH <= WW-2 (run bit at CH, follow flag at WW-1).
module rle_run_fsm #(
    parameter int WW = 36,
    parameter int CH = 34
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [WW-1:0] w_word,
    input  logic          w_valid,
    output logic          w_ready,
    output logic [CH-1:0] s_sample,
    output logic          s_valid,
    input  logic          s_ready
);
    localparam int RUN_W = WW + 2;
    localparam int FLAG  = WW - 1;

    logic             ext_q;
    logic [CH-1:0]    smp_q;
    logic [RUN_W-1:0] run_q;
    logic             take;
    logic             w_fire;

    assign s_valid  = !ext_q && (run_q != '0);
    assign s_sample = smp_q;
    assign take     = s_valid && s_ready;
    assign w_ready  = ext_q || (run_q == '0) || (run_q == RUN_W'(1) && take);
    assign w_fire   = w_valid && w_ready;

    // Load data/extension words and count down the run on each transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_q <= 1'b0;
            smp_q <= '0;
            run_q <= '0;
        end else if (w_fire) begin
            if (ext_q) begin
                run_q <= run_q + RUN_W'({w_word, 1'b0});
                ext_q <= 1'b0;
            end else begin
                smp_q <= w_word[CH-1:0];
                run_q <= RUN_W'(w_word[CH]) + RUN_W'(1);
                ext_q <= w_word[FLAG];
            end
        end else if (take) begin
            run_q <= run_q - RUN_W'(1);
        end
    end

    // R3
    plain_word_emits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (w_valid && w_ready && !ext_q && !w_word[FLAG]) |=> s_valid);

    // R4
    pending_ext_has_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_q |-> (run_q != '0));
endmodule

// File: rtl/rle_limit_gate.sv
`timescale 1ns/1ps
// Module: rle_limit_gate
// Counts transferred samples and closes the output once the limit is met;
// afterwards upstream samples are drained and discarded.
// Assumes limit is held steady while a capture is decoded.
module rle_limit_gate #(
    parameter int CH    = 34,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] limit,
    input  logic [CH-1:0]    s_sample,
    input  logic             s_valid,
    output logic             s_ready,
    output logic [CH-1:0]    o_sample,
    output logic             o_valid,
    input  logic             o_ready
);
    logic [CNT_W-1:0] cnt_q;
    logic             full;

    assign full     = (cnt_q >= limit);
    assign o_valid  = s_valid && !full;
    assign o_sample = s_sample;
    assign s_ready  = o_ready || full;

    // Count every sample handed downstream.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (o_valid && o_ready)
            cnt_q <= cnt_q + 1'b1;
    end

    // R6
    stall_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && !o_ready) |=> (o_valid && $stable(o_sample)));

    // R7
    limit_freezes_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt_q >= limit) && $stable(limit)) |=> $stable(cnt_q));
endmodule

// File: rtl/rle_capture_decoder.sv
`timescale 1ns/1ps
// Module: rle_capture_decoder (top)
// Capture memory words in, expanded samples out: group assembler, then
// run-length interpreter, then sample-limit gate.
// Assumes GRP*NIB == MW and CHANNELS <= MW+NIB-2.
module rle_capture_decoder #(
    parameter int MW       = 32,
    parameter int NIB      = 4,
    parameter int GRP      = 8,
    parameter int CHANNELS = 34,
    parameter int CNT_W    = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [MW-1:0]       in_word,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [CNT_W-1:0]    sample_limit,
    output logic [CHANNELS-1:0] out_sample,
    output logic                out_valid,
    input  logic                out_ready
);
    localparam int WW = MW + NIB;

    logic [WW-1:0]       w_word;
    logic                w_valid;
    logic                w_ready;
    logic [CHANNELS-1:0] s_sample;
    logic                s_valid;
    logic                s_ready;

    rle_group_assembler #(.MW(MW), .NIB(NIB), .GRP(GRP)) asm_i (
        .clk(clk), .rst_n(rst_n),
        .in_word(in_word), .in_valid(in_valid), .in_ready(in_ready),
        .w_word(w_word), .w_valid(w_valid), .w_ready(w_ready)
    );

    rle_run_fsm #(.WW(WW), .CH(CHANNELS)) fsm_i (
        .clk(clk), .rst_n(rst_n),
        .w_word(w_word), .w_valid(w_valid), .w_ready(w_ready),
        .s_sample(s_sample), .s_valid(s_valid), .s_ready(s_ready)
    );

    rle_limit_gate #(.CH(CHANNELS), .CNT_W(CNT_W)) gate_i (
        .clk(clk), .rst_n(rst_n), .limit(sample_limit),
        .s_sample(s_sample), .s_valid(s_valid), .s_ready(s_ready),
        .o_sample(out_sample), .o_valid(out_valid), .o_ready(out_ready)
    );
endmodule

// File: tb/rle_capture_decoder_tb.sv
`timescale 1ns/1ps
// Bench for rle_capture_decoder: a table of 36-bit logical words is packed
// into nine-word groups, and a spec model builds the expected sample list.
module rle_capture_decoder_tb_top;
    localparam int NV = 16;
    localparam logic [35:0] VEC [NV] = '{
        36'h0_0000_0001, 36'h4_0000_0002, 36'h8_0000_0003, 36'h0_0000_0002,
        36'hC_0000_0004, 36'h0_0000_0001, 36'h3_FFFF_FFFF, 36'h8_0000_0005,
        36'h0_0000_0003, 36'h1_2345_6789, 36'h6_0000_0000, 36'h0_0000_0007,
        36'h8_0000_0008, 36'h0_0000_0000, 36'h4_0000_0009, 36'h2_AAAA_AAAA
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] in_word;
    logic        in_valid;
    logic        in_ready;
    logic [31:0] sample_limit;
    logic [33:0] out_sample;
    logic        out_valid;
    logic        out_ready;

    int          total = 0;
    int          fails = 0;
    logic [33:0] exp_s [0:255];
    int          exp_n = 0;
    int          got_n = 0;
    int          bp_mode = 0;
    logic [7:0]  lfsr = 8'hA5;
    logic        hold_pending = 1'b0;
    logic [33:0] held;

    always #2 clk = ~clk;

    rle_capture_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .in_word(in_word), .in_valid(in_valid),
        .in_ready(in_ready), .sample_limit(sample_limit), .out_sample(out_sample),
        .out_valid(out_valid), .out_ready(out_ready)
    );

    task automatic chk(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] expv);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // Spec model: expand the first nw table words, capped at lim samples.
    task automatic build_expected(input int nw, input int lim);
        bit          ext = 0;
        logic [33:0] s = '0;
        longint      r = 0;
        exp_n = 0;
        for (int i = 0; i < nw; i++) begin
            if (!ext) begin
                s = VEC[i][33:0];
                r = longint'(VEC[i][34]) + 1;
                ext = VEC[i][35];
            end else begin
                r = r + (longint'(VEC[i]) << 1);
                ext = 0;
            end
            if (!ext)
                for (longint k = 0; k < r; k++)
                    if (exp_n < lim) begin exp_s[exp_n] = s; exp_n++; end
        end
    endtask

    task automatic do_reset(input int lim);
        rst_n = 1'b0;
        in_valid = 1'b0;
        in_word = '0;
        sample_limit = lim;
        got_n = 0;
        hold_pending = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Called at a negedge; returns at the negedge after the word is taken.
    task automatic push(input logic [31:0] w);
        bit acc;
        in_word = w;
        in_valid = 1'b1;
        forever begin
            acc = in_ready;
            @(negedge clk);
            if (acc) break;
        end
        in_valid = 1'b0;
    endtask

    task automatic send_groups(input int ng);
        logic [31:0] nib;
        for (int g = 0; g < ng; g++) begin
            nib = '0;
            for (int i = 0; i < 8; i++) begin
                push(VEC[g*8+i][31:0]);
                nib[31-4*i -: 4] = VEC[g*8+i][35:32];
            end
            push(nib);
        end
    endtask

    // Output driver and monitor: set out_ready, then sample 1 ns later.
    initial begin
        out_ready = 1'b1;
        forever begin
            @(negedge clk);
            out_ready = (bp_mode == 0) ? 1'b1 : (bp_mode == 2) ? 1'b0 : (lfsr[0] | lfsr[3]);
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            #1;
            if (rst_n) begin
                if (hold_pending) begin
                    // R6 stalled sample must persist unchanged
                    chk(out_valid && out_sample == held, "R6 hold", {1'b0, out_valid, out_sample}, {2'b01, held});
                end
                if (out_valid && out_ready) begin
                    hold_pending = 1'b0;
                    if (got_n < exp_n)
                        chk(out_sample == exp_s[got_n], "R2 R3 R4 sample", {2'b0, out_sample}, {2'b0, exp_s[got_n]});
                    else
                        chk(1'b0, "R7 R8 extra sample", {2'b0, out_sample}, 36'h0);
                    got_n++;
                end else if (out_valid) begin
                    hold_pending = 1'b1;
                    held = out_sample;
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        // Reset state, full stream without backpressure
        bp_mode = 0;
        build_expected(NV, 1000);
        do_reset(1000);
        chk(out_valid == 1'b0, "R1 out_valid", {35'b0, out_valid}, 36'h0);
        chk(in_ready == 1'b1, "R1 in_ready", {35'b0, in_ready}, 36'h1);
        send_groups(2);
        repeat (60) @(negedge clk);
        chk(got_n == exp_n, "R5 R10 count", got_n, exp_n);
        chk(exp_n == 28, "R5 model count", exp_n, 28);

        // Same stream under pseudo-random backpressure
        bp_mode = 1;
        build_expected(NV, 1000);
        do_reset(1000);
        send_groups(2);
        repeat (150) @(negedge clk);
        chk(got_n == exp_n, "R6 count under stall", got_n, exp_n);

        // Sample limit, input still drained
        build_expected(NV, 5);
        do_reset(5);
        send_groups(2);
        repeat (100) @(negedge clk);
        chk(got_n == 5, "R7 limit count", got_n, 5);
        chk(out_valid == 1'b0, "R7 out_valid after limit", {35'b0, out_valid}, 36'h0);
        chk(in_ready == 1'b1, "R7 input drained", {35'b0, in_ready}, 36'h1);

        // Zero limit
        bp_mode = 0;
        build_expected(NV, 0);
        do_reset(0);
        send_groups(2);
        repeat (60) @(negedge clk);
        chk(got_n == 0, "R8 zero limit", got_n, 0);

        // Intake closed while a group drains, including a stalled drain
        bp_mode = 2;
        build_expected(8, 1000);
        do_reset(1000);
        send_groups(1);
        chk(in_ready == 1'b0, "R9 closed after nibble", {35'b0, in_ready}, 36'h0);
        repeat (20) @(negedge clk);
        chk(in_ready == 1'b0, "R9 closed while stalled", {35'b0, in_ready}, 36'h0);
        bp_mode = 0;
        repeat (40) @(negedge clk);
        chk(in_ready == 1'b1, "R9 reopened", {35'b0, in_ready}, 36'h1);
        chk(got_n == 13, "R10 pending flag holds tail", got_n, 13);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule